// File: doc/BRIEF.md
# Debug-Aware Dual-Channel Clock Prescaler

This block produces divided clock enables for timers and serial interfaces. It has two independent divider channels. Each channel counts the cycles on which its own source clock-enable input is high. From that count it produces fifteen tap enables, one for each power-of-two ratio from 1/1 to 1/16384. A peripheral selects one tap as its count or operation clock. The taps are single-cycle enable pulses in the system clock domain, so no clock crosses a domain boundary.

An 8-bit control register is reached through a simple write/read port. Bit 0 starts and stops both channels. Bit 1 sets what happens while the processor is in debug mode: the dividers either keep counting or freeze whenever the debug-status input is high. A stopped channel keeps its count, so it resumes at the same phase.

Top module: `psc_dual`

## Requirements
- R1: After reset the control bits are 0, both counters are 0, every tap is low and the read data is 0.
- R2: While control bit 0 (run) is 0, no channel advances and every tap output is low.
- R3: While `dbg_i` is high and control bit 1 (debug-run) is 0, both channels freeze. While bit 1 is 1, `dbg_i` has no effect.
- R4: A channel advances only on cycles where its own bit of `src_en_i` is high. The two channels count independently.
- R5: Tap n (n = 1..14, output bit `ch*15+n`) pulses high for one cycle when the low n bits of the channel counter are all ones and the channel advances. It therefore fires once every 2^n advance cycles, and the first pulse comes on the 2^n-th advance.
- R6: Tap 0 (output bit `ch*15`) equals the channel's advance condition, which is divide-by-1.
- R7: A frozen or stopped channel holds its counter, and counting resumes from the same value.
- R8: A read strobe returns {6'b0, debug-run, run} on `rdata_o` in the following cycle. Bits 7..2 read as 0 even if they were written as 1. Without a strobe the read data is 0.
- R9: A write takes effect on the taps from the cycle after the write strobe.
- R10: Each counter is 14 bits wide and wraps to 0 after 16384 advances, so the phase of every tap continues unbroken across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_en_i | input | 2 | Per-channel source clock enable |
| dbg_i | input | 1 | Processor debug-mode status |
| wr_en_i | input | 1 | Control register write strobe |
| wdata_i | input | 8 | Control register write data |
| rd_en_i | input | 1 | Control register read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| taps_o | output | 30 | Tap enables, bit ch*15+n is divide-by-2^n of channel ch |

## Verification
The hardest event to reach is the divide-by-16384 tap, together with the counter wrap that follows it. Both occur only after the full 14-bit counter sequence, and any stop, freeze or idle source cycle delays them. The bench models each counter arithmetically. It runs a stretch of more than 32768 cycles with both sources enabled, so every tap fires and each counter wraps at least twice. Before that stretch, random source-enable patterns and frozen debug intervals leave the two counters at different phases. The wrap therefore occurs from a state that earlier stops had to preserve.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned DBG_BIT = 1;

  typedef struct packed {
    logic dbg_run;
    logic run;
  } psc_ctrl_t;
endpackage

// File: rtl/psc_ctrl_reg.sv
`timescale 1ns/1ps
module psc_ctrl_reg
  import psc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output psc_ctrl_t         ctrl_o,
  output logic [CTRL_W-1:0] rdata_o
);
  psc_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.run     <= wdata_i[RUN_BIT];
      ctrl_q.dbg_run <= wdata_i[DBG_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      rdata_o          <= '0;
      rdata_o[RUN_BIT] <= ctrl_q.run;
      rdata_o[DBG_BIT] <= ctrl_q.dbg_run;
    end else begin
      rdata_o <= '0;
    end
  end

  assign ctrl_o = ctrl_q;

  // R9: written value is visible the next cycle
  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_o.run == $past(wdata_i[RUN_BIT]) &&
                 ctrl_o.dbg_run == $past(wdata_i[DBG_BIT])));
  // R8: reserved bits read as zero
  a_r8_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rdata_o[CTRL_W-1:2] == '0);
endmodule

// File: rtl/psc_div_chan.sv
`timescale 1ns/1ps
module psc_div_chan #(
  parameter int unsigned NUM_TAPS = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  output logic [NUM_TAPS-1:0] taps_o
);
  localparam int unsigned CNT_W = NUM_TAPS - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign taps_o[0] = adv_i;

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    assign taps_o[k] = adv_i & (&cnt_q[k-1:0]);
    // R5: a slower tap only fires together with every faster one
    a_r5_tap_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
      taps_o[k] |-> taps_o[k-1]);
  end

  // R7: counter frozen while not advancing
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
  // R10: modular increment on every advance
  a_r10_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/psc_dual.sv
`timescale 1ns/1ps
module psc_dual
  import psc_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned NUM_TAPS = 15
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH-1:0]            src_en_i,
  input  logic                         dbg_i,
  input  logic                         wr_en_i,
  input  logic [CTRL_W-1:0]            wdata_i,
  input  logic                         rd_en_i,
  output logic [CTRL_W-1:0]            rdata_o,
  output logic [NUM_CH*NUM_TAPS-1:0]   taps_o
);
  localparam int unsigned TAP_BITS = NUM_CH * NUM_TAPS;

  psc_ctrl_t         ctrl;
  logic              freeze;
  logic [NUM_CH-1:0] adv;

  psc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rd_en_i (rd_en_i),
    .ctrl_o  (ctrl),
    .rdata_o (rdata_o)
  );

  assign freeze = !ctrl.run || (dbg_i && !ctrl.dbg_run);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign adv[c] = src_en_i[c] & ~freeze;

    psc_div_chan #(.NUM_TAPS(NUM_TAPS)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv[c]),
      .taps_o (taps_o[c*NUM_TAPS +: NUM_TAPS])
    );

    // R4: idle source gives no taps on that channel
    a_r4_src_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !src_en_i[c] |-> taps_o[c*NUM_TAPS +: NUM_TAPS] == '0);
  end

  // R2: stopped block is silent
  a_r2_stop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |-> taps_o == TAP_BITS'(0));
  // R3: debug freeze unless debug-run set
  a_r3_dbg_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_i && !ctrl.dbg_run) |-> taps_o == TAP_BITS'(0));
endmodule

// File: tb/psc_dual_bench.sv
`timescale 1ns/1ps
module psc_dual_bench;
  localparam int NCH = 2;
  localparam int NT  = 15;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NCH-1:0]  src_en = '0;
  logic            dbg = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wdata = '0;
  logic            rd_en = 1'b0;
  logic [7:0]      rdata;
  logic [NCH*NT-1:0] taps;

  int checks = 0;
  int fails  = 0;

  logic [13:0] mcnt [NCH];
  logic        mrun = 1'b0;
  logic        mdbg = 1'b0;
  logic [7:0]  exp_rdata = '0;

  always #4 clk = ~clk;

  psc_dual u_psc_dual (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .src_en_i (src_en),
    .dbg_i    (dbg),
    .wr_en_i  (wr_en),
    .wdata_i  (wdata),
    .rd_en_i  (rd_en),
    .rdata_o  (rdata),
    .taps_o   (taps)
  );

  function automatic logic [NT-1:0] exp_taps(input logic adv, input logic [13:0] cnt);
    logic [NT-1:0] e;
    e[0] = adv;
    for (int k = 1; k < NT; k++) begin
      logic [13:0] m;
      m = (14'd1 << k) - 14'd1;
      e[k] = adv && ((cnt & m) == m);
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic d, input logic w,
                      input logic [7:0] wd, input logic r, input string tag);
    logic [NCH-1:0] adv;
    @(negedge clk);
    src_en = s; dbg = d; wr_en = w; wdata = wd; rd_en = r;
    #1;
    for (int c = 0; c < NCH; c++) begin
      adv[c] = s[c] && mrun && !(d && !mdbg);
      check(tag, 32'(taps[c*NT +: NT]), 32'(exp_taps(adv[c], mcnt[c])));
    end
    check("R8", 32'(rdata), 32'(exp_rdata));
    @(posedge clk);
    for (int c = 0; c < NCH; c++) if (adv[c]) mcnt[c] = mcnt[c] + 14'd1;
    exp_rdata = r ? {6'b0, mdbg, mrun} : 8'h00;
    if (w) begin mrun = wd[0]; mdbg = wd[1]; end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) mcnt[c] = '0;
    src_en = 2'b11;
    repeat (3) @(negedge clk);
    check("R1", 32'(taps), 32'd0);
    check("R1", 32'(rdata), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1/R8: read register after reset
    step(2'b11, 1'b0, 1'b0, 8'h00, 1'b1, "R1");
    // R2: stopped, sources active
    for (int i = 0; i < 20; i++) step(2'b11, 1'b0, 1'b0, 8'h00, 1'b0, "R2");
    // R8/R9: write all ones, reserved bits read back 0
    step(2'b11, 1'b0, 1'b1, 8'hFF, 1'b0, "R9");
    step(2'b11, 1'b0, 1'b0, 8'h00, 1'b1, "R9");
    step(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, "R8");
    // R4/R5/R6: random per-channel sources
    for (int i = 0; i < 3000; i++)
      step(2'($urandom_range(0, 3)), 1'b0, 1'b0, 8'h00, 1'b0, "R4");
    // R3: debug with debug-run=1 keeps running
    for (int i = 0; i < 300; i++) step(2'b11, 1'b1, 1'b0, 8'h00, 1'b0, "R3");
    // R3/R7: debug-run=0 freezes, then resume
    step(2'b11, 1'b0, 1'b1, 8'h01, 1'b0, "R9");
    for (int i = 0; i < 200; i++) step(2'b11, 1'b1, 1'b0, 8'h00, 1'b0, "R3");
    for (int i = 0; i < 500; i++)
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0, 8'h00, 1'b0, "R7");
    step(2'b00, 1'b0, 1'b0, 8'h00, 1'b1, "R8");
    // R2/R7: stop, hold, restart
    step(2'b11, 1'b0, 1'b1, 8'h00, 1'b0, "R2");
    for (int i = 0; i < 50; i++) step(2'b11, 1'b0, 1'b0, 8'h00, 1'b0, "R2");
    step(2'b11, 1'b0, 1'b1, 8'h03, 1'b0, "R9");
    // R5/R10: long full-rate run covers every tap and wraps
    for (int i = 0; i < 34000; i++) step(2'b11, 1'b0, 1'b0, 8'h00, 1'b0, "R10");
    // R5/R6: mixed tail
    for (int i = 0; i < 2000; i++)
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0, 8'h00, 1'b0, "R5");
    step(2'b00, 1'b0, 1'b0, 8'h00, 1'b1, "R8");
    step(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, "R8");
    finish_run();
  end
endmodule